// File: doc/BRIEF.md
# Dual-Pixel Raster Timing Generator

This block produces the raster timing for a 1600 by 1200 flat panel that receives two pixels on every clock over two parallel ports. The first port always carries the left pixel of a pair (even column) and the second port the right pixel (odd column). Because a pair moves on each clock, the horizontal counter counts pairs, so each horizontal interval is half its dot count.

Each clock, the generator drives horizontal and vertical sync, a data-enable strobe, the two column numbers that the pair occupies, and the active line number. A pixel source uses these to fetch and present the right pair. Two complete timing sets are built in: a standard set and a reduced-blanking set. A mode input picks between them, and the choice is taken only at the start of a frame. The polarity of each sync output can be set on its own. All outputs come from registers clocked by the pair clock. The block is a pure source with no handshake: it runs freely once reset is released.

Top module: `dpx_raster_gen`

## Requirements
- R1: During each active clock the even-port index `col_even_o` equals 2k and `col_odd_o` equals 2k+1, where k counts the active clocks of the line from 0. Both indices read 0 while `de_o` is low.
- R2: `de_o` is high only when the horizontal and vertical positions are both inside their active windows. Each frame has exactly H_ACT x V_ACT enabled clocks.
- R3: With `mode_rb`=0 the line is 96 sync, 152 back porch, 800 active and 32 front porch clocks (1080 total). The frame is 3 sync, 46 back porch, 1200 active and 1 front porch lines (1250 total).
- R4: With `mode_rb`=1 the line is 8 sync, 56 back porch, 800 active and 48 front porch clocks (912 total). The frame is 1 sync, 1 back porch, 1200 active and 12 front porch lines (1214 total).
- R5: Both axes run in the order sync, back porch, active, front porch, starting at position 0. The line counter steps only when the horizontal count wraps. `line_idx_o` gives the active line number from 0 and holds steady across a line's active run.
- R6: `hs_pol`/`vs_pol`=1 makes the sync active-high and 0 makes it active-low. Outside its sync interval each sync sits at the complement of its active level.
- R7: Outputs are registered one clock behind the counters. The first clock edge after reset is released presents position (0,0), where both syncs are active and `de_o` is low.
- R8: `mode_rb` is captured only when the counters are at position (0,0). A change made during a frame alters nothing until the next frame starts.
- R9: While `rst_n` is low at a clock edge, both counters clear, `de_o` goes low, all indices go to 0 and each sync is driven to its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pair clock; one pixel pair per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_rb | input | 1 | Timing set select: 0 standard, 1 reduced blanking |
| hs_pol | input | 1 | Horizontal sync active level |
| vs_pol | input | 1 | Vertical sync active level |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable, high on active pairs |
| col_even_o | output | COL_W | Column of the pixel on the even port |
| col_odd_o | output | COL_W | Column of the pixel on the odd port |
| line_idx_o | output | LINE_W | Active line number |

## Verification
If the horizontal counter is off by one, the hsync width or the first enabled clock moves within a single line. The column indices also stop stepping by two between neighbouring active clocks. A line counter that steps at the wrong time moves the vertical sync edges and the frame length by whole lines, and this appears at the next frame boundary. A corrupted mode register does not show until the next frame, where the frame length becomes the length of the other timing set.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
  localparam int TW = 16;

  typedef logic [TW-1:0] tcnt_t;

  // One axis of a timing set, all values in counter units (pairs or lines).
  typedef struct packed {
    tcnt_t sync;
    tcnt_t bp;
    tcnt_t act;
    tcnt_t fp;
  } axis_t;
endpackage

// File: rtl/dpx_mode_hold.sv
module dpx_mode_hold
  import dpx_pkg::*;
#(
  parameter axis_t STD_H = '0,
  parameter axis_t STD_V = '0,
  parameter axis_t RB_H  = '0,
  parameter axis_t RB_V  = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  frame_start,
  input  logic  mode_in,
  output logic  mode_q,
  output axis_t h_tim,
  output axis_t v_tim
);
  logic sel;

  // The frame mode is latched at position (0,0) only.
  always_ff @(posedge clk) begin
    if (!rst_n)           mode_q <= 1'b0;
    else if (frame_start) mode_q <= mode_in;
  end

  // At the first clock of a frame the fresh mode already governs.
  assign sel   = frame_start ? mode_in : mode_q;
  assign h_tim = sel ? RB_H : STD_H;
  assign v_tim = sel ? RB_V : STD_V;
endmodule

// File: rtl/dpx_axis_dec.sv
module dpx_axis_dec
  import dpx_pkg::*;
#(
  parameter int POS_W = 10
) (
  input  tcnt_t             cnt,
  input  axis_t             tim,
  output logic              in_sync,
  output logic              in_act,
  output logic              last,
  output logic [POS_W-1:0]  pos
);
  tcnt_t act_start;
  tcnt_t total;
  tcnt_t rel;

  assign act_start = tim.sync + tim.bp;
  assign total     = act_start + tim.act + tim.fp;
  assign rel       = cnt - act_start;

  assign in_sync = (cnt < tim.sync);
  assign in_act  = (cnt >= act_start) && (rel < tim.act);
  assign last    = (cnt == total - tcnt_t'(1));
  assign pos     = in_act ? POS_W'(rel) : '0;
endmodule

// File: rtl/dpx_axis_cnt.sv
module dpx_axis_cnt
  import dpx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  last,
  output tcnt_t cnt,
  output logic  wrap
);
  assign wrap = en && last;

  always_ff @(posedge clk) begin
    if (!rst_n)  cnt <= '0;
    else if (en) cnt <= last ? '0 : cnt + tcnt_t'(1);
  end
endmodule

// File: rtl/dpx_raster_gen.sv
module dpx_raster_gen
  import dpx_pkg::*;
#(
  parameter int H_ACT   = 800,
  parameter int V_ACT   = 1200,
  parameter int STD_HS  = 96,
  parameter int STD_HBP = 152,
  parameter int STD_HFP = 32,
  parameter int STD_VS  = 3,
  parameter int STD_VBP = 46,
  parameter int STD_VFP = 1,
  parameter int RB_HS   = 8,
  parameter int RB_HBP  = 56,
  parameter int RB_HFP  = 48,
  parameter int RB_VS   = 1,
  parameter int RB_VBP  = 1,
  parameter int RB_VFP  = 12,
  localparam int COL_W  = $clog2(2 * H_ACT),
  localparam int LINE_W = $clog2(V_ACT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_rb,
  input  logic              hs_pol,
  input  logic              vs_pol,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [COL_W-1:0]  col_even_o,
  output logic [COL_W-1:0]  col_odd_o,
  output logic [LINE_W-1:0] line_idx_o
);
  localparam int PAIR_W = COL_W - 1;

  localparam axis_t STD_H = '{sync: TW'(STD_HS), bp: TW'(STD_HBP),
                              act: TW'(H_ACT), fp: TW'(STD_HFP)};
  localparam axis_t STD_V = '{sync: TW'(STD_VS), bp: TW'(STD_VBP),
                              act: TW'(V_ACT), fp: TW'(STD_VFP)};
  localparam axis_t RB_H  = '{sync: TW'(RB_HS), bp: TW'(RB_HBP),
                              act: TW'(H_ACT), fp: TW'(RB_HFP)};
  localparam axis_t RB_V  = '{sync: TW'(RB_VS), bp: TW'(RB_VBP),
                              act: TW'(V_ACT), fp: TW'(RB_VFP)};

  tcnt_t h_cnt, v_cnt;
  axis_t h_tim, v_tim;
  logic  frame_start, mode_act;
  logic  h_sync, h_act, h_last, h_wrap;
  logic  v_sync, v_act, v_last, v_wrap;
  logic  [PAIR_W-1:0] h_pos;
  logic  [LINE_W-1:0] v_pos;
  logic  de_nxt;

  assign frame_start = (h_cnt == '0) && (v_cnt == '0);

  dpx_mode_hold #(
    .STD_H(STD_H), .STD_V(STD_V), .RB_H(RB_H), .RB_V(RB_V)
  ) u_mode (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mode_in(mode_rb),
    .mode_q(mode_act), .h_tim(h_tim), .v_tim(v_tim)
  );

  dpx_axis_dec #(.POS_W(PAIR_W)) u_hdec (
    .cnt(h_cnt), .tim(h_tim), .in_sync(h_sync), .in_act(h_act),
    .last(h_last), .pos(h_pos)
  );

  dpx_axis_dec #(.POS_W(LINE_W)) u_vdec (
    .cnt(v_cnt), .tim(v_tim), .in_sync(v_sync), .in_act(v_act),
    .last(v_last), .pos(v_pos)
  );

  dpx_axis_cnt u_hcnt (
    .clk(clk), .rst_n(rst_n), .en(1'b1), .last(h_last),
    .cnt(h_cnt), .wrap(h_wrap)
  );

  dpx_axis_cnt u_vcnt (
    .clk(clk), .rst_n(rst_n), .en(h_wrap), .last(v_last),
    .cnt(v_cnt), .wrap(v_wrap)
  );

  assign de_nxt = h_act && v_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hsync_o    <= ~hs_pol;
      vsync_o    <= ~vs_pol;
      de_o       <= 1'b0;
      col_even_o <= '0;
      col_odd_o  <= '0;
      line_idx_o <= '0;
    end else begin
      hsync_o    <= ~(h_sync ^ hs_pol);
      vsync_o    <= ~(v_sync ^ vs_pol);
      de_o       <= de_nxt;
      col_even_o <= de_nxt ? {h_pos, 1'b0} : '0;
      col_odd_o  <= de_nxt ? {h_pos, 1'b1} : '0;
      line_idx_o <= de_nxt ? v_pos : '0;
    end
  end

  logic unused_ok;
  assign unused_ok = v_wrap;
endmodule

// File: rtl/dpx_raster_chk.sv
module dpx_raster_chk #(
  parameter int COL_W  = 11,
  parameter int LINE_W = 11,
  parameter int TW     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              mode_q,
  input logic              de_o,
  input logic [COL_W-1:0]  col_even_o,
  input logic [COL_W-1:0]  col_odd_o,
  input logic [LINE_W-1:0] line_idx_o,
  input logic [TW-1:0]     h_cnt,
  input logic [TW-1:0]     v_cnt
);
  logic seen, rst_q;

  always_ff @(posedge clk) begin
    seen  <= 1'b1;
    rst_q <= rst_n;
    if (seen == 1'b1 && rst_q == 1'b0) begin
      // R9
      reset_out_chk: assert (!de_o && col_even_o == '0 && col_odd_o == '0 &&
                             line_idx_o == '0 && h_cnt == '0 && v_cnt == '0)
        else $error("outputs or counters not cleared after reset");
    end
  end

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(mode_q));

  // R1
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_o && $past(de_o) |-> col_even_o == $past(col_even_o) + COL_W'(2));

  // R1
  col_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de_o) |-> col_even_o == '0 && col_odd_o == COL_W'(1));

  // R5
  line_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_o && $past(de_o) |-> $stable(line_idx_o));

  // R5
  h_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_cnt != '0 |-> h_cnt == $past(h_cnt) + TW'(1));

  // R5
  v_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_cnt != $past(v_cnt) |-> h_cnt == '0);
endmodule

bind dpx_raster_gen dpx_raster_chk #(
  .COL_W(COL_W), .LINE_W(LINE_W), .TW(dpx_pkg::TW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mode_q(mode_act),
  .de_o(de_o), .col_even_o(col_even_o), .col_odd_o(col_odd_o),
  .line_idx_o(line_idx_o), .h_cnt(h_cnt), .v_cnt(v_cnt)
);

// File: tb/tb_dpx_raster_gen.sv
module tb_dpx_raster_gen;
  localparam int HA = 4, VA = 3;
  localparam int S_HS = 3, S_HB = 2, S_HF = 2, S_VS = 2, S_VB = 1, S_VF = 1;
  localparam int R_HS = 1, R_HB = 1, R_HF = 3, R_VS = 1, R_VB = 2, R_VF = 2;
  localparam int CW = $clog2(2 * HA);
  localparam int LW = $clog2(VA);

  logic clk = 1'b0;
  logic rst_n = 1'b0, mode = 1'b0, hpol = 1'b1, vpol = 1'b1, fmode = 1'b0;
  always #10 clk = ~clk;

  logic hs, vs, de;
  logic [CW-1:0] ce, co;
  logic [LW-1:0] li;
  logic fhs, fvs, fde;
  logic [10:0] fce, fco, fli;

  dpx_raster_gen #(
    .H_ACT(HA), .V_ACT(VA),
    .STD_HS(S_HS), .STD_HBP(S_HB), .STD_HFP(S_HF),
    .STD_VS(S_VS), .STD_VBP(S_VB), .STD_VFP(S_VF),
    .RB_HS(R_HS), .RB_HBP(R_HB), .RB_HFP(R_HF),
    .RB_VS(R_VS), .RB_VBP(R_VB), .RB_VFP(R_VF)
  ) dut (
    .clk(clk), .rst_n(rst_n), .mode_rb(mode), .hs_pol(hpol), .vs_pol(vpol),
    .hsync_o(hs), .vsync_o(vs), .de_o(de), .col_even_o(ce), .col_odd_o(co),
    .line_idx_o(li)
  );

  dpx_raster_gen dut_full (
    .clk(clk), .rst_n(rst_n), .mode_rb(fmode), .hs_pol(1'b1), .vs_pol(1'b1),
    .hsync_o(fhs), .vsync_o(fvs), .de_o(fde), .col_even_o(fce), .col_odd_o(fco),
    .line_idx_o(fli)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct {
    logic hs, vs, de;
    int ce, co, li;
  } exp_t;
  exp_t q[$];

  // Scoreboard driver: reference raster model for the small instance.
  int mh = 0, mv = 0;
  logic mm = 1'b0;

  task automatic push_expected();
    exp_t e;
    int hsw, hb, vsw, vb, ht, vt;
    bit ha, va;
    if (!rst_n) begin
      e.hs = ~hpol; e.vs = ~vpol; e.de = 1'b0; e.ce = 0; e.co = 0; e.li = 0;
      mh = 0; mv = 0;
    end else begin
      if (mh == 0 && mv == 0) mm = mode;
      hsw = mm ? R_HS : S_HS;  hb = mm ? R_HB : S_HB;
      vsw = mm ? R_VS : S_VS;  vb = mm ? R_VB : S_VB;
      ht  = hsw + hb + HA + (mm ? R_HF : S_HF);
      vt  = vsw + vb + VA + (mm ? R_VF : S_VF);
      ha  = (mh >= hsw + hb) && (mh < hsw + hb + HA);
      va  = (mv >= vsw + vb) && (mv < vsw + vb + VA);
      e.hs = (mh < hsw) ? hpol : ~hpol;
      e.vs = (mv < vsw) ? vpol : ~vpol;
      e.de = ha && va;
      e.ce = e.de ? 2 * (mh - hsw - hb) : 0;
      e.co = e.de ? e.ce + 1 : 0;
      e.li = e.de ? mv - vsw - vb : 0;
      mh++;
      if (mh == ht) begin
        mh = 0; mv++;
        if (mv == vt) mv = 0;
      end
    end
    q.push_back(e);
  endtask

  always @(posedge clk) push_expected();

  // Scoreboard monitor: compares away from the active edge.
  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0 && !finished) begin
      e = q.pop_front();
      chk(hs === e.hs, "R6 hsync", int'(hs), int'(e.hs));
      chk(vs === e.vs, "R6 vsync", int'(vs), int'(e.vs));
      chk(de === e.de, "R2 de", int'(de), int'(e.de));
      chk(int'(ce) == e.ce, "R1 col_even", int'(ce), e.ce);
      chk(int'(co) == e.co, "R1 col_odd", int'(co), e.co);
      chk(int'(li) == e.li, "R5 line_idx", int'(li), e.li);
    end
  end

  // Counts one frame of the small instance; entered on a frame's first sample.
  task automatic run_frame(input int sw_at, input logic sw_val,
                           output int len, output int dcnt);
    logic prev;
    bit done;
    len = 1; dcnt = 0; prev = 1'b1; done = 0;
    while (!done) begin
      @(negedge clk);
      if (len == sw_at) mode = sw_val;
      if (vs && !prev) done = 1;
      else begin
        prev = vs;
        len++;
        if (de) dcnt++;
      end
    end
  endtask

  // Measures the default-parameter instance from reset release.
  task automatic full_measure(input int htot, input int hsw, input int hb,
                              input int vsw, input int vb, input string tag);
    int n_tot, hs_cnt, vs_cnt, first, de_cnt, last_co, first_ce;
    n_tot = (vsw + vb + 1) * htot;
    hs_cnt = 0; vs_cnt = 0; first = -1; de_cnt = 0; last_co = -1; first_ce = -1;
    @(negedge clk) rst_n = 1'b1;
    for (int n = 0; n < n_tot; n++) begin
      @(negedge clk);
      if (n < htot && fhs) hs_cnt++;
      if (fvs) vs_cnt++;
      if (fde) begin
        if (first < 0) begin first = n; first_ce = int'(fce); end
        de_cnt++;
        last_co = int'(fco);
      end
    end
    chk(hs_cnt == hsw, {tag, " hsync width"}, hs_cnt, hsw);
    chk(vs_cnt == vsw * htot, {tag, " vsync width"}, vs_cnt, vsw * htot);
    chk(first == (vsw + vb) * htot + hsw + hb, {tag, " first de"}, first,
        (vsw + vb) * htot + hsw + hb);
    chk(de_cnt == 800, {tag, " de per line"}, de_cnt, 800);
    chk(first_ce == 0, {tag, " first even column"}, first_ce, 0);
    chk(last_co == 1599, {tag, " last odd column"}, last_co, 1599);
  endtask

  initial begin
    int len, dcnt;
    repeat (3) @(negedge clk);
    // R9: reset state at the ports
    chk(de === 1'b0 && ce == '0 && li == '0, "R9 reset outputs", int'(de), 0);
    chk(hs === 1'b0 && vs === 1'b0, "R9 reset sync inactive", int'(hs), 0);

    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R7: first registered position is (0,0)
    chk(hs === 1'b1 && vs === 1'b1 && de === 1'b0, "R7 first position", int'({hs, vs, de}), 6);

    run_frame(30, 1'b1, len, dcnt);
    chk(len == 77, "R8 mid-frame switch ignored", len, 77);
    chk(dcnt == HA * VA, "R2 enabled clocks per frame", dcnt, HA * VA);
    run_frame(20, 1'b0, len, dcnt);
    chk(len == 72, "R4 reduced frame length", len, 72);
    chk(dcnt == HA * VA, "R2 enabled clocks reduced", dcnt, HA * VA);
    run_frame(-1, 1'b0, len, dcnt);
    chk(len == 77, "R3 standard frame length after return", len, 77);

    // R6: flip both polarities mid-frame
    @(negedge clk) begin hpol = 1'b0; vpol = 1'b0; end
    @(negedge clk);
    while (!de) @(negedge clk);
    chk(hs === 1'b1 && vs === 1'b1, "R6 inactive level active-low", int'({hs, vs}), 3);
    repeat (90) @(negedge clk);

    // R9: reset taken mid-frame
    rst_n = 1'b0;
    @(negedge clk);
    chk(de === 1'b0 && ce == '0 && co == '0 && li == '0, "R9 mid-frame reset", int'(de), 0);
    chk(hs === 1'b1 && vs === 1'b1, "R9 sync inactive active-low", int'({hs, vs}), 3);

    // R3: default standard timing
    fmode = 1'b0;
    @(negedge clk);
    full_measure(1080, 96, 152, 3, 46, "R3");

    // R4: default reduced-blanking timing
    rst_n = 1'b0;
    fmode = 1'b1;
    repeat (2) @(negedge clk);
    full_measure(912, 8, 56, 1, 1, "R4");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule